// File: doc/BRIEF.md
# Clause-22 MDIO Management Master with Background PHY Scan

This block is a register-mapped management controller for Ethernet PHYs. It generates the management clock and drives a tri-stateable data pin to run Clause-22 read and write frames. A host reaches it through a small 32-bit register bus with a 2-bit word address. Reads return data one cycle after the read strobe. The host fills a single access register with a PHY address, a register number, optional write data and a GO bit. It then polls until GO drops.

While the engine is enabled and no host request is waiting, it reads a fixed status register of each PHY address in turn. It records in a 32-bit mask which addresses answered their last poll. A host request never aborts a scan frame. It takes the bus at the next frame boundary, ahead of any further scan read. Clearing the enable bit stops the bus after the frame in flight, and an idle flag reports when that has happened.

Top module: `mdio_ctrl`

## Requirements
- R1: After reset the control word (address 1) reads with bit 31 (idle) = 1, bit 30 (enable) = 0 and divider bits 15:0 = 3. The alive mask (address 2) and the access word (address 3) both read as zero.
- R2: The management clock period is (divider + 1) input clock cycles. A divider of 0 acts as 1.
- R3: Address 0 reads the revision, with the major number in bits 15:8 and the minor number in bits 7:0. With the default parameters this is 0x00000107.
- R4: A host write to address 3 with bit 31 (GO) set starts one transaction. The access word layout is:
  - bit 30: 1 = write, 0 = read
  - bit 29: ACK
  - bits 25:21: register number
  - bits 20:16: PHY address
  - bits 15:0: data
  GO reads back as 1 until the frame ends, and then it clears by itself.
- R5: A frame consists of the following fields, sent MSB first with bits changing after the falling clock edge:
  - 32 preamble ones
  - start 01
  - opcode (10 for read, 01 for write)
  - 5-bit PHY address
  - 5-bit register number
  - 2 turnaround bits
  - 16 data bits
  On a read the pin is released from the first turnaround bit on, and input is sampled on rising edges. ACK is set only when the second turnaround bit is low. The data field is replaced only when ACK is set.
- R6: A write to the access register while GO is still set has no effect on any field.
- R7: A write transaction drives turnaround 10 and the 16 data bits, and it leaves ACK at 0 when it completes.
- R8: With enable set, the scan polls addresses 0 to 31 cyclically. Bit n of the alive mask equals the ACK of the most recent poll of address n.
- R9: A host request is delayed by at most one scan frame. GO clears within 2*66*(divider+1)+10 cycles of the write.
- R10: Clearing enable lets the current frame finish, after which idle reads 1 and no frame starts, host request included. Setting enable again resumes work, and a pending GO is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word address: 0 revision, 1 control, 2 alive mask, 3 access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data pin output value |
| mdio_oe | output | 1 | Data pin output enable |
| mdio_i | input | 1 | Data pin input value |

## Verification
A PHY model decodes frames from the pins. It answers only at addresses in a changeable mask and holds its own register file. The bench therefore sees three kinds of error:
- a wrong turnaround sample, which shows up as a false ACK on a silent address or fresh data after a missed ACK;
- a stale alive bit once the responder mask changes;
- an off-by-one in the bit counter, which corrupts read data or write data.

It also goes after three timing cases:
- a second access word written while GO is high, which a faulty design would adopt;
- an odd divider, where a faulty design would get the clock period wrong;
- a disable issued mid-frame, where a faulty design would either cut the frame or serve a pending request while disabled.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_AW = 5;
  localparam int REG_AW = 5;
  localparam int DAT_W  = 16;
  localparam int FRM_W  = 64;
  localparam logic [6:0] LAST_CNT = 7'd64;  // bits sent before the closing fall
  localparam logic [6:0] TA_IDX   = 7'd46;  // first turnaround bit index
  localparam logic [6:0] ACK_CNT  = 7'd48;  // counter value while bit 47 is on the wire

  typedef struct packed {
    logic              wr;
    logic [PHY_AW-1:0] phy;
    logic [REG_AW-1:0] regn;
    logic [DAT_W-1:0]  data;
  } mdio_req_t;

  function automatic logic [FRM_W-1:0] build_frame(input mdio_req_t r);
    build_frame = {32'hFFFF_FFFF, 2'b01, (r.wr ? 2'b01 : 2'b10), r.phy, r.regn,
                   (r.wr ? 2'b10 : 2'b11), (r.wr ? r.data : 16'hFFFF)};
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W:0]   eff;
  logic [DIV_W:0]   half;

  always_comb begin
    eff      = (div == '0) ? {{DIV_W{1'b0}}, 1'b1} : {1'b0, div};
    half     = (eff + 1'b1) >> 1;
    rise_evt = ({1'b0, cnt} == (half - 1'b1));
    fall_evt = ({1'b0, cnt} >= eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (fall_evt) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (rise_evt) mdc <= 1'b1;
    end
  end

  // R2: a falling event always leaves the clock low, a rising one high
  assert_mdc_low_R2: assert property (@(posedge clk) disable iff (rst)
    fall_evt |=> !mdc);
  assert_mdc_high_R2: assert property (@(posedge clk) disable iff (rst)
    (rise_evt && !fall_evt) |=> mdc);
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_evt,
  input  logic             fall_evt,
  input  logic             start,
  input  mdio_req_t        req,
  input  logic             mdio_i,
  output logic             busy,
  output logic             done,
  output logic             ack,
  output logic [DAT_W-1:0] rdata,
  output logic             mdio_o,
  output logic             mdio_oe
);
  logic [FRM_W-1:0] sr;
  logic [6:0]       bcnt;
  logic             rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; ack <= 1'b0; rdata <= '0;
      mdio_o <= 1'b1; mdio_oe <= 1'b0; sr <= '0; bcnt <= '0; rd_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          bcnt <= '0;
          rd_q <= !req.wr;
          sr   <= build_frame(req);
          ack  <= 1'b0;
        end
      end else begin
        if (fall_evt) begin
          if (bcnt == LAST_CNT) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
          end else begin
            mdio_o  <= sr[FRM_W-1];
            sr      <= {sr[FRM_W-2:0], 1'b1};
            mdio_oe <= !(rd_q && (bcnt >= TA_IDX));
            bcnt    <= bcnt + 7'd1;
          end
        end
        if (rise_evt && rd_q && (bcnt != '0)) begin
          if (bcnt == ACK_CNT) ack <= !mdio_i;
          else if (bcnt > ACK_CNT) rdata <= {rdata[DAT_W-2:0], mdio_i};
        end
      end
    end
  end

  // R5: pin released once a read reaches its turnaround
  assert_read_release_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_q && (bcnt > TA_IDX)) |-> !mdio_oe);
  // R10: nothing driven between frames
  assert_quiet_between_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);
  // R4: completion pulse lasts one cycle
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int               DIV_W     = 16,
  parameter logic [DIV_W-1:0] DIV_RESET = 3,
  parameter logic [7:0]       VER_MAJOR = 8'h01,
  parameter logic [7:0]       VER_MINOR = 8'h07,
  parameter logic [4:0]       SCAN_REG  = 5'd1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int         NPHY     = 1 << PHY_AW;
  localparam logic [1:0] A_VER    = 2'd0;
  localparam logic [1:0] A_CTRL   = 2'd1;
  localparam logic [1:0] A_ALIVE  = 2'd2;
  localparam logic [1:0] A_ACC    = 2'd3;

  logic              en;
  logic [DIV_W-1:0]  div;
  logic              go;
  logic              acc_ack;
  mdio_req_t         acc;
  logic [NPHY-1:0]   alive;
  logic [PHY_AW-1:0] scan_addr;
  logic              cur_user;
  logic              rise_evt, fall_evt;
  logic              eng_busy, eng_done, eng_ack;
  logic [DAT_W-1:0]  eng_rdata;
  logic              start;
  mdio_req_t         req;
  logic              idle;
  logic              unused_bits;

  assign unused_bits = ^{bus_wdata[31], bus_wdata[29:DIV_W], bus_wdata[29:26]};

  always_comb begin
    idle  = !en && !eng_busy;
    start = en && !eng_busy && !eng_done;
    if (go) req = acc;
    else    req = '{wr: 1'b0, phy: scan_addr, regn: SCAN_REG, data: '0};
  end

  mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .div(div), .mdc(mdc),
    .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame_eng u_eng (
    .clk(clk), .rst(rst), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .start(start), .req(req), .mdio_i(mdio_i),
    .busy(eng_busy), .done(eng_done), .ack(eng_ack), .rdata(eng_rdata),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0;
      div <= DIV_RESET;
    end else if (bus_wr && bus_addr == A_CTRL) begin
      en  <= bus_wdata[30];
      div <= bus_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      go <= 1'b0; acc_ack <= 1'b0; acc <= '0; cur_user <= 1'b0; scan_addr <= '0;
    end else begin
      if (start) cur_user <= go;
      if (eng_done) begin
        if (cur_user) begin
          go      <= 1'b0;
          acc_ack <= eng_ack;
          if (!acc.wr && eng_ack) acc.data <= eng_rdata;
        end else begin
          scan_addr <= scan_addr + 1'b1;
        end
      end
      if (bus_wr && bus_addr == A_ACC && !go) begin
        go      <= bus_wdata[31];
        acc_ack <= 1'b0;
        acc     <= '{wr: bus_wdata[30], regn: bus_wdata[25:21],
                     phy: bus_wdata[20:16], data: bus_wdata[15:0]};
      end
    end
  end

  for (genvar g = 0; g < NPHY; g++) begin : g_alive
    always_ff @(posedge clk) begin
      if (rst) alive[g] <= 1'b0;
      else if (eng_done && !cur_user && scan_addr == PHY_AW'(g)) alive[g] <= eng_ack;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_VER:   bus_rdata <= {16'h0, VER_MAJOR, VER_MINOR};
        A_CTRL:  bus_rdata <= {idle, en, {(30-DIV_W){1'b0}}, div};
        A_ALIVE: bus_rdata <= alive;
        default: bus_rdata <= {go, acc.wr, acc_ack, 3'b000, acc.regn, acc.phy, acc.data};
      endcase
    end
  end

  // R4: GO drops only at the end of a host frame
  assert_go_clear_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(go) |-> $past(eng_done && cur_user));
  // R6: access fields untouched by a write while GO is high
  assert_busy_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (go && bus_wr && bus_addr == A_ACC && !eng_done) |=> $stable(acc));
  // R9: a pending request takes the very next frame
  assert_host_first_R9: assert property (@(posedge clk) disable iff (rst)
    (en && go && !eng_busy && !eng_done) |=> (eng_busy && cur_user));
  // R10: no frame starts while disabled
  assert_no_frame_disabled_R10: assert property (@(posedge clk) disable iff (rst)
    (!en && !eng_busy) |=> !eng_busy);
endmodule

// File: tb/mdio_ctrl_bench.sv
`timescale 1ns/1ps
module mdio_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int total = 0, bad = 0;
  bit fin = 1'b0;

  always #5 clk = ~clk;

  mdio_ctrl u_mdio_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // ---------------- PHY model ----------------
  logic [31:0] alive_mask = 32'h0;
  logic [15:0] mem [0:1023];
  int          mode = 0, ones = 0, hcnt = 0, bodycnt = 0, drv = 0;
  logic [13:0] hdr = '0;
  logic [17:0] wbody = '0;
  logic [4:0]  mphy = '0, mreg = '0;
  logic [15:0] rword = '0;
  logic        rd_act = 1'b0;
  logic        line_b;

  initial for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 40503 + 17);

  always @(posedge mdc) begin
    line_b = mdio_oe ? mdio_o : mdio_i;
    case (mode)
      0: begin
        if (line_b) ones++;
        else begin
          if (ones >= 32) begin mode = 1; hdr = {13'b0, line_b}; hcnt = 1; end
          ones = 0;
        end
      end
      1: begin
        hdr = {hdr[12:0], line_b};
        hcnt++;
        if (hcnt == 14) begin
          mphy = hdr[9:5]; mreg = hdr[4:0]; bodycnt = 0;
          if (hdr[11:10] == 2'b10) begin
            mode = 3;
            if (alive_mask[mphy]) begin rd_act = 1'b1; drv = 0; rword = mem[{mphy, mreg}]; end
          end else if (hdr[11:10] == 2'b01) mode = 2;
          else begin mode = 0; ones = 0; end
        end
      end
      2: begin
        wbody = {wbody[16:0], line_b};
        bodycnt++;
        if (bodycnt == 18) begin
          if (alive_mask[mphy] && wbody[17:16] == 2'b10) mem[{mphy, mreg}] = wbody[15:0];
          mode = 0; ones = 0;
        end
      end
      default: begin
        bodycnt++;
        if (bodycnt == 18) begin mode = 0; ones = 0; end
      end
    endcase
  end

  always @(negedge mdc) begin
    if (rd_act) begin
      drv++;
      if (drv == 1) mdio_i = 1'b1;
      else if (drv == 2) mdio_i = 1'b0;
      else if (drv <= 18) mdio_i = rword[18 - drv];
      else begin mdio_i = 1'b1; rd_act = 1'b0; end
    end
  end

  bit mon_on = 1'b0, oe_seen = 1'b0;
  always @(posedge clk) if (mon_on && mdio_oe) oe_seen = 1'b1;

  // ---------------- helpers ----------------
  function automatic logic [31:0] acc_word(input logic g, input logic wr, input logic [4:0] rg,
                                           input logic [4:0] ph, input logic [15:0] d);
    acc_word = {g, wr, 1'b0, 3'b000, rg, ph, d};
  endfunction

  function automatic int go_bound(input int d);
    int e;
    e = (d == 0) ? 1 : d;
    go_bound = 2 * 66 * (e + 1) + 10;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_go(output int cyc, output logic [31:0] w);
    cyc = 2;  // the write itself
    do begin bus_read(2'd3, w); cyc += 2; end while (w[31] && cyc < 20000);
  endtask

  task automatic measure_period(output int p);
    time t0;
    @(posedge mdc); @(posedge mdc); t0 = $time;
    @(posedge mdc); p = int'(($time - t0) / 10);
  endtask

  // one host access, checked against the model
  task automatic host_op(input logic wr, input logic [4:0] ph, input logic [4:0] rg,
                         input logic [15:0] d, input int dv);
    logic [31:0] w;
    logic [15:0] exp_d;
    logic        exp_a;
    int          cyc;
    exp_a = (!wr && alive_mask[ph]);
    exp_d = exp_a ? mem[{ph, rg}] : d;
    bus_write(2'd3, acc_word(1'b1, wr, rg, ph, d));
    wait_go(cyc, w);
    check(!w[31], "R4 go clear", w, {1'b0, w[30:0]});
    check(cyc <= go_bound(dv), "R9 defer bound", 32'(cyc), 32'(go_bound(dv)));
    check(w[29] == exp_a, wr ? "R7 write ack" : "R5 read ack", {31'b0, w[29]}, {31'b0, exp_a});
    check(w[15:0] == exp_d && w[25:21] == rg && w[20:16] == ph,
          wr ? "R7 fields" : "R5 read data", w, acc_word(1'b0, wr, rg, ph, exp_d) | {2'b0, exp_a, 29'b0});
    if (wr && alive_mask[ph])
      check(mem[{ph, rg}] == d, "R7 phy reg written", {16'b0, mem[{ph, rg}]}, {16'b0, d});
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      bad++; total++;
      $display("FAIL R9 watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    logic [31:0] w, wa;
    int p, cyc;
    process::self().srandom(32'd1234);
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1, R3
    bus_read(2'd1, w); check(w == 32'h8000_0003, "R1 control", w, 32'h8000_0003);
    bus_read(2'd2, w); check(w == 32'h0, "R1 alive", w, 32'h0);
    bus_read(2'd3, w); check(w == 32'h0, "R1 access", w, 32'h0);
    bus_read(2'd0, w); check(w == 32'h0000_0107, "R3 version", w, 32'h0000_0107);

    // R2
    measure_period(p); check(p == 4, "R2 period div3", 32'(p), 32'd4);
    bus_write(2'd1, 32'h0000_0006);
    measure_period(p); check(p == 7, "R2 period div6", 32'(p), 32'd7);
    bus_write(2'd1, 32'h0000_0000);
    measure_period(p); check(p == 2, "R2 period div0", 32'(p), 32'd2);

    // R8 scan
    alive_mask = 32'h8421_1013;
    bus_write(2'd1, 32'h4000_0001);
    repeat (10000) @(posedge clk);
    bus_read(2'd2, w); check(w == alive_mask, "R8 alive mask", w, alive_mask);

    // directed reads: answering and silent PHY
    host_op(1'b0, 5'd0, 5'd2, 16'h0000, 1);
    host_op(1'b0, 5'd3, 5'd9, 16'hBEEF, 1);
    // directed write then readback
    host_op(1'b1, 5'd4, 5'd7, 16'h1234, 1);
    host_op(1'b0, 5'd4, 5'd7, 16'h0000, 1);

    // R6: second word while GO high is dropped
    bus_write(2'd3, acc_word(1'b1, 1'b0, 5'd5, 5'd1, 16'h0));
    bus_write(2'd3, acc_word(1'b1, 1'b1, 5'd6, 5'd12, 16'h5555));
    wait_go(cyc, w);
    wa = acc_word(1'b0, 1'b0, 5'd5, 5'd1, mem[{5'd1, 5'd5}]) | 32'h2000_0000;
    check(w == wa, "R6 busy write ignored", w, wa);
    check(mem[{5'd12, 5'd6}] == 16'(({5'd12, 5'd6}) * 40503 + 17), "R6 no stray write",
          {16'b0, mem[{5'd12, 5'd6}]}, 32'(16'(({5'd12, 5'd6}) * 40503 + 17)));

    // random mix
    for (int k = 0; k < 24; k++) begin
      logic [4:0] ph;
      ph = (k % 3 == 0) ? 5'($urandom_range(0, 31)) : ((k % 2) ? 5'd31 : 5'd12);
      host_op(1'($urandom_range(0, 1)), ph, 5'($urandom_range(0, 31)), 16'($urandom), 1);
    end

    // R8 tracking a changed responder set
    alive_mask = 32'h0000_0F01;
    repeat (10000) @(posedge clk);
    bus_read(2'd2, w); check(w == alive_mask, "R8 alive update", w, alive_mask);

    // R10 disable / re-enable
    bus_write(2'd1, 32'h0000_0001);
    cyc = 2;
    do begin bus_read(2'd1, w); cyc += 2; end while (!w[31] && cyc < 1000);
    check(w[31] && cyc <= 66 * 2 + 10, "R10 idle after frame", 32'(cyc), 32'(66 * 2 + 10));
    mon_on = 1'b1;
    bus_write(2'd3, acc_word(1'b1, 1'b0, 5'd3, 5'd8, 16'h0));
    repeat (600) @(posedge clk);
    bus_read(2'd3, w); check(w[31], "R10 go held while disabled", w, w | 32'h8000_0000);
    check(!oe_seen, "R10 pin quiet while disabled", {31'b0, oe_seen}, 32'h0);
    mon_on = 1'b0;
    bus_write(2'd1, 32'h4000_0001);
    wait_go(cyc, w);
    check(!w[31] && w[29] && w[15:0] == mem[{5'd8, 5'd3}], "R10 pending served on enable",
          w, acc_word(1'b0, 1'b0, 5'd3, 5'd8, mem[{5'd8, 5'd3}]) | 32'h2000_0000);
    check(cyc <= go_bound(1), "R9 defer after enable", 32'(cyc), 32'(go_bound(1)));

    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule